// File: doc/BRIEF.md
# Seconds/Minutes Watchdog Timer

A configuration-space watchdog that counts a 16-bit value down toward zero. Each step of the count is either one pulse of the once-per-second tick input or one minute made of a parameterised number of those ticks. One configuration bit selects which. Software loads the count through a byte-wide index/data register port. The high byte is staged first. The low-byte write then loads the whole value and starts counting. Writing the count again is the keepalive, and loading zero stops the timer.

When the count reaches zero from one, the watchdog sets a sticky timeout status bit. It also fires a fixed-length reset pulse on each reset output that was enabled at that moment. There are two such outputs: an active-high keyboard-style reset and an active-low power-good line. A four-bit interrupt-select field is kept in the configuration register and driven out for routing elsewhere. A single interrupt flag is raised while the status bit is set and that field is non-zero.

Top module: `wdt_unit_timer`

## Requirements
- R1: The register indices are 0x71 (control), 0x72 (configuration), 0x73 (count low byte) and 0x74 (count high byte). After reset, all four read 0x00, any other index reads 0x00, `kbrst_o` is 0, `pgood_o` is 1 and `sts_o` is 0.
- R2: Configuration bit 7 selects the unit. When it is 1, the count drops by one on each `sec_tick` pulse. When it is 0, the count drops by one every TICKS_PER_MIN tick pulses, counted from the last load.
- R3: A write to 0x74 only stages the high byte, so reads of 0x74 keep returning the live count's high byte. A write to 0x73 loads {staged high byte, written byte} into the count, visible on the next clock. It also restarts the minute prescaler.
- R4: While the count is zero, the timer is stopped: ticks neither change the count nor cause a timeout. Loading zero stops a running timer without a timeout.
- R5: Reloading the count before it reaches zero restarts the countdown from the new value, and no timeout occurs.
- R6: When a unit step takes the count from 1 to 0, control bit 0 (`sts_o`) becomes 1 on that clock edge.
- R7: If configuration bit 6 is 1 at the timeout, `kbrst_o` is 1 for exactly PULSE_CLKS clocks, starting right after the timeout edge. Otherwise it stays 0.
- R8: If configuration bit 4 is 1 at the timeout, `pgood_o` is 0 for exactly PULSE_CLKS clocks, starting right after the timeout edge. Otherwise it stays 1.
- R9: Writing a 1 to control bit 0 clears the status. Writing 0 there leaves it unchanged. A timeout in the same cycle as a clearing write leaves the status set.
- R10: `irq_o` is 1 exactly when the status is set and configuration bits 3:0 (`irq_sel_o`) are non-zero.
- R11: Configuration bits 7, 6, 4 and 3:0 read back as written. Bit 5 is reserved and always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_idx | input | 8 | Register index for reads and writes |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_rdata | output | 8 | Read data for `reg_idx`, combinational |
| sec_tick | input | 1 | One-clock pulse once per second |
| kbrst_o | output | 1 | Keyboard-style reset pulse, active high |
| pgood_o | output | 1 | Power-good line, driven low during a reset pulse |
| sts_o | output | 1 | Sticky timeout status (control bit 0) |
| irq_o | output | 1 | Timeout interrupt flag, gated by the select field |
| irq_sel_o | output | 4 | Interrupt-select field from configuration bits 3:0 |

## Verification
The bench builds the block with TICKS_PER_MIN = 4 and keeps PULSE_CLKS at its default of 16. A short minute makes minute-mode countdowns, including a timeout, reachable in a few dozen ticks. The bench can then compare them step by step against seconds mode. The full pulse length stays in place, so the exact 16-clock width of both reset outputs is measured as built. The 16-bit count path is still exercised through staged high-byte loads.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;

    localparam logic [BYTE_W-1:0] IDX_CTRL = 8'h71;
    localparam logic [BYTE_W-1:0] IDX_CFG  = 8'h72;
    localparam logic [BYTE_W-1:0] IDX_CLO  = 8'h73;
    localparam logic [BYTE_W-1:0] IDX_CHI  = 8'h74;

    localparam logic [BYTE_W-1:0] CFG_WR_MASK = 8'hDF;
    localparam int                STS_BIT     = 0;

    typedef struct packed {
        logic       unit_sec;
        logic       kb_en;
        logic       rsv;
        logic       pg_en;
        logic [3:0] irq_sel;
    } cfg_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_CFG,
        SEL_CLO,
        SEL_CHI
    } reg_sel_e;

    typedef struct packed {
        logic             ld;
        logic [CNT_W-1:0] val;
    } cnt_load_t;

    function automatic reg_sel_e decode_idx(input logic [BYTE_W-1:0] idx);
        reg_sel_e s;
        case (idx)
            IDX_CTRL: s = SEL_CTRL;
            IDX_CFG:  s = SEL_CFG;
            IDX_CLO:  s = SEL_CLO;
            IDX_CHI:  s = SEL_CHI;
            default:  s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] idx_i,
    input  logic [BYTE_W-1:0] wdata_i,
    input  logic              we_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              expire_i,
    output cfg_t              cfg_o,
    output cnt_load_t         load_o,
    output logic              sts_o,
    output logic [BYTE_W-1:0] rdata_o
);

    reg_sel_e          sel;
    cfg_t              cfg_q;
    logic [BYTE_W-1:0] stage_hi_q;
    logic              sts_q;
    logic              sts_clr;

    assign sel     = decode_idx(idx_i);
    assign sts_clr = we_i && (sel == SEL_CTRL) && wdata_i[STS_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q      <= '0;
            stage_hi_q <= '0;
        end else if (we_i) begin
            if (sel == SEL_CFG) cfg_q      <= cfg_t'(wdata_i & CFG_WR_MASK);
            if (sel == SEL_CHI) stage_hi_q <= wdata_i;
        end
    end

    // a timeout in the same cycle as a clearing write keeps the flag set
    always_ff @(posedge clk) begin
        if (rst)           sts_q <= 1'b0;
        else if (expire_i) sts_q <= 1'b1;
        else if (sts_clr)  sts_q <= 1'b0;
    end

    always_comb begin
        load_o.ld  = we_i && (sel == SEL_CLO);
        load_o.val = {stage_hi_q, wdata_i};
    end

    always_comb begin
        case (sel)
            SEL_CTRL: rdata_o = BYTE_W'(sts_q);
            SEL_CFG:  rdata_o = cfg_q;
            SEL_CLO:  rdata_o = cnt_i[BYTE_W-1:0];
            SEL_CHI:  rdata_o = cnt_i[CNT_W-1:BYTE_W];
            default:  rdata_o = '0;
        endcase
    end

    assign cfg_o = cfg_q;
    assign sts_o = sts_q;

endmodule

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
    parameter int TICKS_PER_MIN = 60
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic unit_sec_i,
    input  logic clear_i,
    output logic unit_o
);

    generate
        if (TICKS_PER_MIN <= 1) begin : g_passthru
            assign unit_o = tick_i;
        end else begin : g_divide
            localparam int PW = $clog2(TICKS_PER_MIN);
            localparam logic [PW-1:0] LAST = PW'(TICKS_PER_MIN - 1);

            logic [PW-1:0] pre_q;
            logic          wrap;

            assign wrap = tick_i && (pre_q == LAST);

            always_ff @(posedge clk) begin
                if (rst || clear_i || unit_sec_i) pre_q <= '0;
                else if (wrap)                    pre_q <= '0;
                else if (tick_i)                  pre_q <= pre_q + 1'b1;
            end

            assign unit_o = unit_sec_i ? tick_i : wrap;
        end
    endgenerate

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  cnt_load_t        load_i,
    input  logic             unit_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             idle_o,
    output logic             expire_o
);

    logic [CNT_W-1:0] cnt_q;
    logic             step;

    assign idle_o   = (cnt_q == '0);
    assign step     = unit_i && !idle_o && !load_i.ld;
    assign expire_o = step && (cnt_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst)            cnt_q <= '0;
        else if (load_i.ld) cnt_q <= load_i.val;
        else if (step)      cnt_q <= cnt_q - 1'b1;
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
    parameter int PULSE_CLKS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic fire_i,
    input  logic kb_en_i,
    input  logic pg_en_i,
    output logic kbrst_o,
    output logic pgood_o
);

    localparam int PCW = $clog2(PULSE_CLKS + 1);

    logic [PCW-1:0] left_q;
    logic           kb_lat_q;
    logic           pg_lat_q;
    logic           active;

    assign active = (left_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q   <= '0;
            kb_lat_q <= 1'b0;
            pg_lat_q <= 1'b0;
        end else if (fire_i) begin
            left_q   <= PCW'(PULSE_CLKS);
            kb_lat_q <= kb_en_i;
            pg_lat_q <= pg_en_i;
        end else if (active) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign kbrst_o = active && kb_lat_q;
    assign pgood_o = !(active && pg_lat_q);

endmodule

// File: rtl/wdt_unit_timer.sv
module wdt_unit_timer
    import wdt_pkg::*;
#(
    parameter int TICKS_PER_MIN = 60,
    parameter int PULSE_CLKS    = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  reg_idx,
    input  logic [7:0]  reg_wdata,
    input  logic        reg_we,
    output logic [7:0]  reg_rdata,
    input  logic        sec_tick,
    output logic        kbrst_o,
    output logic        pgood_o,
    output logic        sts_o,
    output logic        irq_o,
    output logic [3:0]  irq_sel_o
);

    cfg_t             cfg_q;
    cnt_load_t        cnt_load;
    logic [CNT_W-1:0] cnt_q;
    logic             cnt_idle;
    logic             cnt_expire;
    logic             unit_step;

    wdt_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .idx_i    (reg_idx),
        .wdata_i  (reg_wdata),
        .we_i     (reg_we),
        .cnt_i    (cnt_q),
        .expire_i (cnt_expire),
        .cfg_o    (cfg_q),
        .load_o   (cnt_load),
        .sts_o    (sts_o),
        .rdata_o  (reg_rdata)
    );

    wdt_prescale #(.TICKS_PER_MIN(TICKS_PER_MIN)) u_prescale (
        .clk        (clk),
        .rst        (rst),
        .tick_i     (sec_tick),
        .unit_sec_i (cfg_q.unit_sec),
        .clear_i    (cnt_load.ld || cnt_idle),
        .unit_o     (unit_step)
    );

    wdt_counter u_counter (
        .clk      (clk),
        .rst      (rst),
        .load_i   (cnt_load),
        .unit_i   (unit_step),
        .cnt_o    (cnt_q),
        .idle_o   (cnt_idle),
        .expire_o (cnt_expire)
    );

    wdt_pulse #(.PULSE_CLKS(PULSE_CLKS)) u_pulse (
        .clk     (clk),
        .rst     (rst),
        .fire_i  (cnt_expire),
        .kb_en_i (cfg_q.kb_en),
        .pg_en_i (cfg_q.pg_en),
        .kbrst_o (kbrst_o),
        .pgood_o (pgood_o)
    );

    assign irq_sel_o = cfg_q.irq_sel;
    assign irq_o     = sts_o && (cfg_q.irq_sel != '0);

endmodule

// File: rtl/wdt_unit_timer_chk.sv
module wdt_unit_timer_chk
    import wdt_pkg::*;
#(
    parameter int PULSE_CLKS = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] cnt,
    input cnt_load_t        load,
    input logic             expire,
    input cfg_t             cfg,
    input logic             kbrst,
    input logic             pgood,
    input logic             sts,
    input logic             irq
);

    localparam int RW = $clog2(PULSE_CLKS + 1) + 1;

    logic [RW-1:0] kb_run;

    always_ff @(posedge clk) begin
        if (rst || expire || !kbrst) kb_run <= '0;
        else                         kb_run <= kb_run + 1'b1;
    end

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (!load.ld && cnt != '0) |=> (cnt == $past(cnt) || cnt == $past(cnt) - 1'b1)); // R2

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
        load.ld |=> (cnt == $past(load.val))); // R3

    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (cnt == '0 && !load.ld) |=> (cnt == '0 && !expire)); // R4

    AST_STATUS_ON_EXPIRY: assert property (@(posedge clk) disable iff (rst)
        expire |=> sts); // R6

    AST_KB_PULSE_START: assert property (@(posedge clk) disable iff (rst)
        (expire && cfg.kb_en) |=> kbrst); // R7

    AST_KB_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        kbrst |-> (kb_run < RW'(PULSE_CLKS))); // R7

    AST_PG_PULSE_START: assert property (@(posedge clk) disable iff (rst)
        (expire && cfg.pg_en) |=> !pgood); // R8

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        irq |-> (sts && cfg.irq_sel != '0)); // R10

    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
        !cfg.rsv); // R11

endmodule

bind wdt_unit_timer wdt_unit_timer_chk #(.PULSE_CLKS(PULSE_CLKS)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .cnt    (cnt_q),
    .load   (cnt_load),
    .expire (cnt_expire),
    .cfg    (cfg_q),
    .kbrst  (kbrst_o),
    .pgood  (pgood_o),
    .sts    (sts_o),
    .irq    (irq_o)
);

// File: tb/wdt_unit_timer_tb.sv
`timescale 1ns/1ps
module wdt_unit_timer_tb;

    localparam int TPM   = 4;
    localparam int PULSE = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] reg_idx = 8'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic       reg_we = 1'b0;
    logic [7:0] reg_rdata;
    logic       sec_tick = 1'b0;
    logic       kbrst_o, pgood_o, sts_o, irq_o;
    logic [3:0] irq_sel_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    wdt_unit_timer #(.TICKS_PER_MIN(TPM), .PULSE_CLKS(PULSE)) u_dut (
        .clk(clk), .rst(rst), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata), .sec_tick(sec_tick),
        .kbrst_o(kbrst_o), .pgood_o(pgood_o), .sts_o(sts_o),
        .irq_o(irq_o), .irq_sel_o(irq_sel_o)
    );

    typedef struct packed {
        logic [7:0]  cfg;
        logic [15:0] cnt;
        logic [7:0]  ticks;
        logic [15:0] exp_cnt;
        logic        exp_sts;
        logic        exp_kb;
        logic        exp_pg_low;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{8'hD0, 16'd3,     8'd3, 16'd0,     1'b1, 1'b1, 1'b1},
        '{8'hC0, 16'd5,     8'd2, 16'd3,     1'b0, 1'b0, 1'b0},
        '{8'h80, 16'd1,     8'd1, 16'd0,     1'b1, 1'b0, 1'b0},
        '{8'h50, 16'd2,     8'd8, 16'd0,     1'b1, 1'b1, 1'b1},
        '{8'h40, 16'd2,     8'd7, 16'd1,     1'b0, 1'b0, 1'b0},
        '{8'h90, 16'h0102,  8'd2, 16'h0100,  1'b0, 1'b0, 1'b0},
        '{8'hC0, 16'd0,     8'd5, 16'd0,     1'b0, 1'b0, 1'b0}
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] idx, input logic [7:0] d);
        reg_idx = idx; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] idx, output logic [7:0] d);
        reg_idx = idx;
        #1;
        d = reg_rdata;
    endtask

    task automatic tick();
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic load(input logic [15:0] v);
        wr(8'h74, v[15:8]);
        wr(8'h73, v[7:0]);
    endtask

    task automatic rd_cnt(output logic [15:0] v);
        logic [7:0] lo, hi;
        rd(8'h73, lo);
        rd(8'h74, hi);
        v = {hi, lo};
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0]  b;
        logic [15:0] c;
        int          n;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(8'h71, b); check("R1 ctrl reset", b, 8'h00);
        rd(8'h72, b); check("R1 cfg reset", b, 8'h00);
        rd(8'h73, b); check("R1 cnt lo reset", b, 8'h00);
        rd(8'h74, b); check("R1 cnt hi reset", b, 8'h00);
        rd(8'h70, b); check("R1 unmapped", b, 8'h00);
        check("R1 kbrst reset", kbrst_o, 1'b0);
        check("R1 pgood reset", pgood_o, 1'b1);
        check("R1 sts reset", sts_o, 1'b0);

        // table: R2 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            wr(8'h72, VECS[i].cfg);
            load(VECS[i].cnt);
            for (int t = 0; t < int'(VECS[i].ticks); t++) tick();
            rd_cnt(c);
            check($sformatf("R2 vec%0d count", i), c, VECS[i].exp_cnt);
            check($sformatf("R6 vec%0d status", i), sts_o, VECS[i].exp_sts);
            check($sformatf("R7 vec%0d kbrst", i), kbrst_o, VECS[i].exp_kb);
            check($sformatf("R8 vec%0d pgood", i), pgood_o, !VECS[i].exp_pg_low);
            repeat (PULSE + 4) @(negedge clk);
            load(16'd0);
            wr(8'h71, 8'h01);
        end

        // R11 reserved bit and readback
        wr(8'h72, 8'hFF);
        rd(8'h72, b); check("R11 cfg readback", b, 8'hDF);
        check("R11 irq_sel field", irq_sel_o, 4'hF);

        // R3 staged high byte
        wr(8'h72, 8'h80);
        wr(8'h74, 8'h12);
        rd(8'h74, b); check("R3 hi staged not live", b, 8'h00);
        wr(8'h73, 8'h34);
        rd_cnt(c); check("R3 full load", c, 16'h1234);
        load(16'd0);

        // R5 keepalive, then R7 pulse width
        wr(8'h72, 8'hC0);
        load(16'd3);
        tick(); tick();
        wr(8'h73, 8'd3);
        tick(); tick();
        rd_cnt(c); check("R5 reload count", c, 16'd1);
        check("R5 no timeout", sts_o, 1'b0);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
        n = 0;
        while (kbrst_o && n < 100) begin
            n++;
            @(negedge clk);
        end
        check("R7 kbrst width", n, PULSE);
        check("R8 pgood untouched", pgood_o, 1'b1);
        check("R6 status set", sts_o, 1'b1);

        // R9 W1C, R10 irq gating
        wr(8'h71, 8'h00);
        check("R9 write 0 keeps", sts_o, 1'b1);
        check("R10 irq sel zero", irq_o, 1'b0);
        wr(8'h72, 8'hC5);
        check("R10 irq sel nonzero", irq_o, 1'b1);
        wr(8'h71, 8'h01);
        check("R9 write 1 clears", sts_o, 1'b0);
        check("R10 irq after clear", irq_o, 1'b0);

        // R4 stop by loading zero
        load(16'd5);
        tick();
        wr(8'h73, 8'h00);
        rd_cnt(c); check("R4 stop load", c, 16'd0);
        tick(); tick(); tick();
        rd_cnt(c); check("R4 stopped count", c, 16'd0);
        check("R4 no timeout", sts_o, 1'b0);

        // R9 timeout wins over clear
        load(16'd1);
        tick();
        check("R9 pre set", sts_o, 1'b1);
        repeat (PULSE + 2) @(negedge clk);
        load(16'd1);
        sec_tick = 1'b1;
        reg_idx = 8'h71; reg_wdata = 8'h01; reg_we = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0; reg_we = 1'b0;
        check("R9 set wins", sts_o, 1'b1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule